// File: doc/BRIEF.md
# Frame and Multiframe Marker Generator

This block runs beside a lane datapath that moves one 32-bit word, four octets, per link clock. For every accepted word it marks which octets begin a frame and which begin a multiframe. It also pulses once on each word that opens a multiframe, which gives the local multiframe clock edge. The frame length F (in octets) and the multiframe length K (in frames) are set at run time. Frames may begin at any octet position in a word, and odd F is supported, so frame starts move across the word from one word to the next.

The markers describe the word that is presented in the same cycle. They are combinational in `in_valid`, `restart` and the registered counter state. The block has no ready output and never stalls the datapath. A cycle with `in_valid` low carries no word: its markers are low and the counters keep their values, so the pattern resumes where it stopped. Configuration inputs are sampled only on a `restart` cycle. The restart word itself is unmarked, and the next accepted word opens a new multiframe at octet 0. If the sampled setting is illegal, the block flags it and stays silent until a legal setting is captured by another restart.

Top module: `fmk_marker_gen`

## Requirements
- R1: Marker bit i refers to octet i, which occupies data bits [8i+7:8i], so octet 0 is bits [7:0]. `sof[i]` is high exactly when octet i is the first octet of a frame, with frames of F octets laid back to back over consecutive accepted words.
- R2: `somf[i]` is high only on the first octet of frame 0 of a multiframe of K frames. Every high `somf` bit has its `sof` bit high too.
- R3: `lmfc_pulse` is high for one cycle on each accepted word whose octet 0 begins a multiframe. Only `somf[0]` is ever high, and accepted words between pulses number F*K/4.
- R4: With `in_valid` low, `sof`, `somf` and `lmfc_pulse` are all low and the counter position holds.
- R5: A cycle with `restart` high clears the octet and frame counters and captures `cfg_f`/`cfg_k`. Its markers are low. The next accepted word (legal setting) has `sof[0]`, `somf[0]` and `lmfc_pulse` high.
- R6: Changes on `cfg_f` or `cfg_k` without a restart have no effect on the markers or on `cfg_error`.
- R7: A captured setting is legal when F is 1, 2 or 4..MAX_F, K is 1..MAX_K, F*K >= 17 and F*K is a multiple of 4. For an illegal setting, `cfg_error` is high from the cycle after the restart and all markers stay low.
- R8: After reset, `cfg_error` is high and all markers are low until a restart captures a legal setting.
- R9: Odd F, for example 5 or 7, gives frame starts that fall on different octet positions from word to word. Where F is below 4, a single word holds several frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_f | input | $clog2(MAX_F+1) | Octets per frame, captured on restart |
| cfg_k | input | $clog2(MAX_K+1) | Frames per multiframe, captured on restart |
| restart | input | 1 | Realign counters and capture configuration |
| in_valid | input | 1 | Current datapath word is accepted |
| sof | output | 4 | Start-of-frame flag per octet |
| somf | output | 4 | Start-of-multiframe flag per octet |
| lmfc_pulse | output | 1 | Word opens a multiframe |
| cfg_error | output | 1 | Captured F/K setting is illegal |

## Verification
The bench targets several specific corner cases:
- F of 1 and 2, where every word holds four or two frame starts. A walker that steps only once per word would miss starts here.
- Odd F of 5 and 7, where frame starts move around the word. A wrap error would show up as a `sof` bit on the wrong octet.
- F=256 with K=1, the longest frame and a 64-word multiframe. An undersized counter would produce early pulses.
- Illegal settings: F=3, F above the maximum, K=0, K=33, F*K below 17, and F*K not a multiple of 4. A weak check would let markers through.
- Random gaps in `in_valid`, configuration changes without a restart, and restarts in the middle of a multiframe. A design that advances on idle cycles, or that picks up configuration early, loses alignment against the reference model.

// File: rtl/fmk_pkg.sv
package fmk_pkg;
  // octets carried by one datapath word
  localparam int WORD_OCTETS = 4;
  // minimum octets in a multiframe (K * F lower bound)
  localparam int MIN_MF_OCTETS = 17;
endpackage

// File: rtl/fmk_cfg_hold.sv
module fmk_cfg_hold #(
  parameter int MAX_F = 256,
  parameter int MAX_K = 32,
  localparam int FW = $clog2(MAX_F + 1),
  localparam int KW = $clog2(MAX_K + 1),
  localparam int PW = FW + KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [FW-1:0] cfg_f,
  input  logic [KW-1:0] cfg_k,
  output logic [FW-1:0] act_f,
  output logic [KW-1:0] act_k,
  output logic          cfg_bad
);
  import fmk_pkg::*;

  logic [PW-1:0] prod;
  logic f_ok, k_ok, span_ok, quad_ok, legal;

  always_comb begin
    prod    = {{KW{1'b0}}, cfg_f} * {{FW{1'b0}}, cfg_k};
    f_ok    = (cfg_f == FW'(1)) || (cfg_f == FW'(2)) ||
              ((cfg_f >= FW'(4)) && (cfg_f <= FW'(MAX_F)));
    k_ok    = (cfg_k != '0) && (cfg_k <= KW'(MAX_K));
    span_ok = prod >= PW'(MIN_MF_OCTETS);
    quad_ok = (prod[1:0] == 2'b00);
    legal   = f_ok && k_ok && span_ok && quad_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_f   <= '0;
      act_k   <= '0;
      cfg_bad <= 1'b1;
    end else if (restart) begin
      act_f   <= cfg_f;
      act_k   <= cfg_k;
      cfg_bad <= !legal;
    end
  end

  // R6: captured setting only moves on a restart
  a_r6_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ($stable(act_f) && $stable(act_k) && $stable(cfg_bad)));
endmodule

// File: rtl/fmk_octet_walk.sv
module fmk_octet_walk #(
  parameter int MAX_F = 256,
  parameter int MAX_K = 32,
  localparam int FW = $clog2(MAX_F + 1),
  localparam int KW = $clog2(MAX_K + 1),
  localparam int NO = fmk_pkg::WORD_OCTETS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic [FW-1:0] act_f,
  input  logic [KW-1:0] act_k,
  output logic [NO-1:0] sof_raw,
  output logic [NO-1:0] somf_raw
);
  localparam logic [FW-1:0] F_ONE = FW'(1);
  localparam logic [KW-1:0] K_ONE = KW'(1);

  logic [FW-1:0] pos, nxt_pos, p;
  logic [KW-1:0] frm, nxt_frm, r;

  // walk the four octets of the word, wrapping frame and multiframe as needed
  always_comb begin
    p = pos;
    r = frm;
    for (int i = 0; i < NO; i++) begin
      sof_raw[i]  = (p == '0);
      somf_raw[i] = (p == '0) && (r == '0);
      if (p + F_ONE == act_f) begin
        p = '0;
        r = (r + K_ONE == act_k) ? '0 : r + K_ONE;
      end else begin
        p = p + F_ONE;
      end
    end
    nxt_pos = p;
    nxt_frm = r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pos <= '0;
      frm <= '0;
    end else if (advance) begin
      pos <= nxt_pos;
      frm <= nxt_frm;
    end
  end

  // R5: restart leaves the walker at octet 0 of frame 0
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pos == '0 && frm == '0));

  // R4: no accepted word, no movement
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> ($stable(pos) && $stable(frm)));
endmodule

// File: rtl/fmk_marker_gen.sv
module fmk_marker_gen #(
  parameter int MAX_F = 256,
  parameter int MAX_K = 32,
  localparam int FW = $clog2(MAX_F + 1),
  localparam int KW = $clog2(MAX_K + 1),
  localparam int PW = FW + KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] cfg_f,
  input  logic [KW-1:0] cfg_k,
  input  logic          restart,
  input  logic          in_valid,
  output logic [3:0]    sof,
  output logic [3:0]    somf,
  output logic          lmfc_pulse,
  output logic          cfg_error
);
  import fmk_pkg::*;

  logic [FW-1:0] act_f;
  logic [KW-1:0] act_k;
  logic          cfg_bad;
  logic          advance;
  logic [WORD_OCTETS-1:0] sof_raw, somf_raw;

  fmk_cfg_hold #(.MAX_F(MAX_F), .MAX_K(MAX_K)) u_cfg (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .cfg_f(cfg_f), .cfg_k(cfg_k),
    .act_f(act_f), .act_k(act_k), .cfg_bad(cfg_bad)
  );

  assign advance = in_valid && !restart && !cfg_bad;

  fmk_octet_walk #(.MAX_F(MAX_F), .MAX_K(MAX_K)) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
    .act_f(act_f), .act_k(act_k),
    .sof_raw(sof_raw), .somf_raw(somf_raw)
  );

  assign sof        = advance ? sof_raw  : '0;
  assign somf       = advance ? somf_raw : '0;
  assign lmfc_pulse = advance && somf_raw[0];
  assign cfg_error  = cfg_bad;

  // ---------------- checker state ----------------
  logic [PW-1:0] period, gap;
  logic          fresh;

  assign period = ({{KW{1'b0}}, act_f} * {{FW{1'b0}}, act_k}) >> 2;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      gap   <= '0;
      fresh <= 1'b1;
    end else if (advance) begin
      fresh <= 1'b0;
      gap   <= lmfc_pulse ? '0 : gap + PW'(1);
    end
  end

  // R2: multiframe start is always a frame start
  a_r2_somf_in_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (somf & ~sof) == 4'b0000);

  // R3: multiframe starts only on octet 0
  a_r3_somf_octet0: assert property (@(posedge clk) disable iff (!rst_n)
    somf[3:1] == 3'b000);

  // R3: pulses spaced by F*K/4 accepted words
  a_r3_lmfc_period: assert property (@(posedge clk) disable iff (!rst_n)
    (lmfc_pulse && !fresh) |-> (gap == period - PW'(1)));

  // R4: idle cycles are unmarked
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (sof == 4'b0000 && !lmfc_pulse));

  // R5: first accepted word after restart opens a multiframe
  a_r5_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh && advance) |-> (sof[0] && somf[0] && lmfc_pulse));

  // R7: illegal setting silences all markers
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> (sof == 4'b0000 && somf == 4'b0000 && !lmfc_pulse));
endmodule

// File: tb/fmk_marker_gen_test.sv
`timescale 1ns/1ps
module fmk_marker_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cfg_f = '0;
  logic [5:0] cfg_k = '0;
  logic       restart = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] sof, somf;
  logic       lmfc_pulse, cfg_error;

  int checks = 0, fails = 0;
  bit cmp_on = 0, done = 0;
  string phase = "R8 reset";

  // reference state
  int  mf = 0, mk = 0, mpos = 0, mfr = 0;
  bit  merr = 1;
  logic [3:0] es, em;
  bit  el;

  always #2.5 clk = ~clk;

  fmk_marker_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_f(cfg_f), .cfg_k(cfg_k),
    .restart(restart), .in_valid(in_valid),
    .sof(sof), .somf(somf), .lmfc_pulse(lmfc_pulse), .cfg_error(cfg_error)
  );

  function automatic bit legal(int f, int k);
    return (f == 1 || f == 2 || (f >= 4 && f <= 256)) && k >= 1 && k <= 32 &&
           f * k >= 17 && (f * k) % 4 == 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  // compare and step the model away from the active edge
  always @(negedge clk) if (cmp_on) begin
    es = '0; em = '0; el = 0;
    if (in_valid && !restart && !merr) begin
      el = (mpos == 0 && mfr == 0);
      for (int i = 0; i < 4; i++) begin
        es[i] = (mpos == 0);
        em[i] = (mpos == 0 && mfr == 0);
        mpos++;
        if (mpos == mf) begin
          mpos = 0;
          mfr = (mfr + 1) % mk;
        end
      end
    end
    chk(sof == es, "R1", "sof", int'(sof), int'(es));
    chk(somf == em, "R2", "somf", int'(somf), int'(em));
    chk(lmfc_pulse == el, "R3", "lmfc_pulse", int'(lmfc_pulse), int'(el));
    chk(cfg_error == merr, "R7", "cfg_error", int'(cfg_error), int'(merr));
    if (restart) begin
      mf = int'(cfg_f); mk = int'(cfg_k); merr = !legal(mf, mk);
      mpos = 0; mfr = 0;
    end
  end

  task automatic do_restart(int f, int k, string tag);
    @(posedge clk); #1;
    phase = tag;
    cfg_f = 9'(f); cfg_k = 6'(k); restart = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    restart = 1'b0;
  endtask

  task automatic run(int n, int pct);
    for (int i = 0; i < n; i++) begin
      in_valid = ($urandom_range(99) < pct);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1;
    // R8: before any restart, nothing is marked even with words flowing
    @(negedge clk);
    chk(cfg_error == 1'b1 && sof == 4'b0 && !lmfc_pulse, "R8", "reset state",
        int'({cfg_error, sof}), 'h10);
    #1 in_valid = 1'b1; cfg_f = 9'd4; cfg_k = 6'd8;
    run(20, 100);

    do_restart(1, 20, "R1 F=1 K=20");   run(120, 100);
    do_restart(2, 10, "R9 F=2 K=10");   run(120, 80);
    do_restart(4, 5,  "R3 F=4 K=5");    run(100, 100);
    do_restart(5, 4,  "R9 odd F=5 K=4"); run(150, 100);
    do_restart(7, 4,  "R9 odd F=7 K=4"); run(150, 70);
    do_restart(6, 6,  "R2 F=6 K=6");    run(150, 100);
    do_restart(256, 1, "R3 F=256 K=1"); run(300, 100);
    do_restart(8, 32, "R3 F=8 K=32");   run(200, 100);

    // R4: idle gaps, position must hold
    do_restart(5, 8, "R4 gaps F=5 K=8"); run(400, 40);

    // R6: configuration changes without restart are ignored
    phase = "R6 no-restart cfg change";
    cfg_f = 9'd3; cfg_k = 6'd0; run(80, 100);
    cfg_f = 9'd12; cfg_k = 6'd7; run(80, 60);

    // R5: restart in mid multiframe
    run(13, 100);
    do_restart(10, 2, "R5 mid-stream restart F=10 K=2"); run(60, 100);
    run(7, 100);
    do_restart(10, 2, "R5 second restart");  run(40, 90);

    // R7: illegal settings
    do_restart(3, 8,   "R7 F=3");          run(30, 100);
    do_restart(300, 4, "R7 F>max");        run(30, 100);
    do_restart(4, 0,   "R7 K=0");          run(30, 100);
    do_restart(4, 33,  "R7 K=33");         run(30, 100);
    do_restart(2, 8,   "R7 F*K<17");       run(30, 100);
    do_restart(5, 5,   "R7 F*K not x4");   run(30, 100);
    do_restart(1, 18,  "R7 F=1 K=18");     run(30, 100);
    // recovery from an illegal setting
    do_restart(9, 4,   "R7 recover F=9 K=4"); run(120, 85);
    do_restart(2, 32,  "R1 F=2 K=32");     run(100, 100);

    in_valid = 1'b0;
    run(5, 0);
    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule